// File: doc/BRIEF.md
# Diagnostic threshold alarm monitor

This block watches three live monitor readings of an optical link module: the internal temperature, the supply voltage and the receive modulation margin. It compares each reading against its own alarm and warning limits and presents the results as four flag bytes for a host to read: a main alarm byte, an auxiliary alarm byte, a main warning byte and an auxiliary warning byte.

Temperature is a 16-bit two's-complement reading in 1/256 degree C steps. Supply voltage is a 16-bit unsigned reading in 100 microvolt steps. Margin is an 8-bit two's-complement reading in 0.2 dB steps, and it has only low limits. The limits arrive as parallel inputs from storage outside the block. The power-on limit values are kept as package constants.

The flags are recomputed and registered on every sample strobe and hold between strobes. The conversion front end, the serial host bus and the limit storage are separate blocks.

Top module: `diag_limit_monitor`

## Requirements
- R1: While rst_ni is low, all four flag bytes read 0x00, and they stay 0x00 until the first sample strobe after reset.
- R2: Temperature high flag: bit 7 of the main byte is set when the reading, taken as signed two's complement, is strictly greater than the high limit. A reading equal to the limit leaves the bit clear.
- R3: Temperature low flag: bit 6 of the main byte is set when the signed reading is strictly less than the low limit. A reading equal to the limit leaves the bit clear.
- R4: Supply high flag: bit 5 of the main byte is set when the reading, taken as unsigned, is strictly greater than the high limit. For example, 0xFFFF is above every limit.
- R5: Supply low flag: bit 4 of the main byte is set when the unsigned reading is strictly less than the low limit.
- R6: Margin low flag: bit 5 of the auxiliary byte is set when the signed 8-bit margin is strictly less than the low limit. For example, 0xF0 (-16) is below 0x08.
- R7: The alarm bytes use only the alarm limits, and the warning bytes use only the warning limits. Both pairs of bytes share the same bit layout, and each pair is evaluated independently of the other.
- R8: The reserved bits always read 0. These are bits 3..0 of both main bytes, and bits 7..6 and 4..0 of both auxiliary bytes.
- R9: The flags take new values only at a clock edge where sample_vld_i is high, and they are visible from the following cycle. Between strobes they hold, whatever the readings and limits do.
- R10: Flags do not latch. A strobe with an in-range reading clears a flag that an earlier strobe set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_vld_i | input | 1 | New set of readings is valid this cycle |
| temp_i | input | 16 | Temperature reading, signed |
| vcc_i | input | 16 | Supply voltage reading, unsigned |
| margin_i | input | 8 | Modulation margin reading, signed |
| temp_hi_alm_i | input | 16 | Temperature high alarm limit |
| temp_lo_alm_i | input | 16 | Temperature low alarm limit |
| temp_hi_wrn_i | input | 16 | Temperature high warning limit |
| temp_lo_wrn_i | input | 16 | Temperature low warning limit |
| vcc_hi_alm_i | input | 16 | Supply high alarm limit |
| vcc_lo_alm_i | input | 16 | Supply low alarm limit |
| vcc_hi_wrn_i | input | 16 | Supply high warning limit |
| vcc_lo_wrn_i | input | 16 | Supply low warning limit |
| mgn_lo_alm_i | input | 8 | Margin low alarm limit |
| mgn_lo_wrn_i | input | 8 | Margin low warning limit |
| alarm_main_o | output | 8 | Alarm byte: temperature and supply flags |
| alarm_aux_o | output | 8 | Alarm byte: margin flag |
| warn_main_o | output | 8 | Warning byte: temperature and supply flags |
| warn_aux_o | output | 8 | Warning byte: margin flag |

## Verification
The assertions check the following on every cycle:
- a strobe with a signed temperature above its high alarm limit raises the flag one cycle later;
- a strobe with an unsigned supply below its low alarm limit raises that flag one cycle later;
- a margin at or above the warning limit leaves the margin warning flag clear;
- the four output bytes stay stable in any cycle without a strobe.

Only the bench scenarios can show the rest:
- the equality boundaries of each compare;
- the sign handling at the ends of the range (0x8000, 0x7FFF, 0xFFFF, 0xF0);
- the independence of the alarm limits from the warning limits;
- the clearing of flags by a later in-range strobe;
- the reset state.

// File: rtl/dlm_pkg.sv
package dlm_pkg;
  localparam int BYTE_W = 8;
  localparam int TEMP_W = 16;
  localparam int VCC_W  = 16;
  localparam int MGN_W  = 8;
  localparam int N_LVL  = 2;   // 0: alarm, 1: warning

  localparam int POS_T_HI = 7;
  localparam int POS_T_LO = 6;
  localparam int POS_V_HI = 5;
  localparam int POS_V_LO = 4;
  localparam int POS_M_LO = 5;

  localparam logic [TEMP_W-1:0] DEF_TEMP_HI_ALM = 16'h7300;
  localparam logic [TEMP_W-1:0] DEF_TEMP_LO_ALM = 16'hD800;
  localparam logic [TEMP_W-1:0] DEF_TEMP_HI_WRN = 16'h6900;
  localparam logic [TEMP_W-1:0] DEF_TEMP_LO_WRN = 16'hE700;
  localparam logic [VCC_W-1:0]  DEF_VCC_HI_ALM  = 16'h9858;
  localparam logic [VCC_W-1:0]  DEF_VCC_LO_ALM  = 16'h6978;
  localparam logic [VCC_W-1:0]  DEF_VCC_HI_WRN  = 16'h8DCC;
  localparam logic [VCC_W-1:0]  DEF_VCC_LO_WRN  = 16'h7404;
  localparam logic [MGN_W-1:0]  DEF_MGN_LO_ALM  = 8'h08;
  localparam logic [MGN_W-1:0]  DEF_MGN_LO_WRN  = 8'h12;

  typedef struct packed {
    logic t_hi;
    logic t_lo;
    logic v_hi;
    logic v_lo;
    logic m_lo;
  } lvl_flags_t;
endpackage

// File: rtl/dlm_cmp.sv
module dlm_cmp #(
  parameter int W          = 16,
  parameter bit SIGNED_CMP = 1'b1,
  parameter bit ABOVE      = 1'b1   // 1: val > lim, 0: val < lim
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] lim_i,
  output logic         hit_o
);
  logic gt, lt;

  generate
    if (SIGNED_CMP) begin : g_sgn
      assign gt = $signed(val_i) > $signed(lim_i);
      assign lt = $signed(val_i) < $signed(lim_i);
    end else begin : g_uns
      assign gt = val_i > lim_i;
      assign lt = val_i < lim_i;
    end
  endgenerate

  generate
    if (ABOVE) begin : g_above
      assign hit_o = gt;
    end else begin : g_below
      assign hit_o = lt;
    end
  endgenerate
endmodule

// File: rtl/dlm_chan.sv
module dlm_chan
  import dlm_pkg::*;
#(
  parameter int W          = 16,
  parameter bit SIGNED_CMP = 1'b1,
  parameter bit HAS_HIGH   = 1'b1,
  localparam int NDIR      = HAS_HIGH ? 2 : 1
) (
  input  logic [W-1:0]                    val_i,
  // [level][dir][bits], dir 0 = low limit, dir 1 = high limit
  input  logic [N_LVL-1:0][NDIR-1:0][W-1:0] lim_i,
  output logic [N_LVL-1:0][NDIR-1:0]        flag_o
);
  generate
    for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
      for (genvar d = 0; d < NDIR; d++) begin : g_dir
        dlm_cmp #(
          .W         (W),
          .SIGNED_CMP(SIGNED_CMP),
          .ABOVE     (d == 1)
        ) i_cmp (
          .val_i(val_i),
          .lim_i(lim_i[l][d]),
          .hit_o(flag_o[l][d])
        );
      end
    end
  endgenerate
endmodule

// File: rtl/dlm_flag_reg.sv
module dlm_flag_reg
  import dlm_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sample_vld_i,
  input  lvl_flags_t [N_LVL-1:0] flags_d_i,
  output logic [N_LVL-1:0][BYTE_W-1:0] main_o,
  output logic [N_LVL-1:0][BYTE_W-1:0] aux_o
);
  lvl_flags_t [N_LVL-1:0] flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           flags_q <= '0;
    else if (sample_vld_i) flags_q <= flags_d_i;
  end

  generate
    for (genvar l = 0; l < N_LVL; l++) begin : g_pack
      always_comb begin
        main_o[l]           = '0;
        main_o[l][POS_T_HI] = flags_q[l].t_hi;
        main_o[l][POS_T_LO] = flags_q[l].t_lo;
        main_o[l][POS_V_HI] = flags_q[l].v_hi;
        main_o[l][POS_V_LO] = flags_q[l].v_lo;
        aux_o[l]            = '0;
        aux_o[l][POS_M_LO]  = flags_q[l].m_lo;
      end
    end
  endgenerate

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_vld_i |=> $stable(main_o) && $stable(aux_o));
endmodule

// File: rtl/diag_limit_monitor.sv
module diag_limit_monitor
  import dlm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_vld_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [VCC_W-1:0]  vcc_i,
  input  logic [MGN_W-1:0]  margin_i,
  input  logic [TEMP_W-1:0] temp_hi_alm_i,
  input  logic [TEMP_W-1:0] temp_lo_alm_i,
  input  logic [TEMP_W-1:0] temp_hi_wrn_i,
  input  logic [TEMP_W-1:0] temp_lo_wrn_i,
  input  logic [VCC_W-1:0]  vcc_hi_alm_i,
  input  logic [VCC_W-1:0]  vcc_lo_alm_i,
  input  logic [VCC_W-1:0]  vcc_hi_wrn_i,
  input  logic [VCC_W-1:0]  vcc_lo_wrn_i,
  input  logic [MGN_W-1:0]  mgn_lo_alm_i,
  input  logic [MGN_W-1:0]  mgn_lo_wrn_i,
  output logic [BYTE_W-1:0] alarm_main_o,
  output logic [BYTE_W-1:0] alarm_aux_o,
  output logic [BYTE_W-1:0] warn_main_o,
  output logic [BYTE_W-1:0] warn_aux_o
);
  localparam int LVL_ALM = 0;
  localparam int LVL_WRN = 1;

  logic [N_LVL-1:0][1:0][TEMP_W-1:0] temp_lim;
  logic [N_LVL-1:0][1:0][VCC_W-1:0]  vcc_lim;
  logic [N_LVL-1:0][0:0][MGN_W-1:0]  mgn_lim;
  logic [N_LVL-1:0][1:0]             temp_hit, vcc_hit;
  logic [N_LVL-1:0][0:0]             mgn_hit;
  lvl_flags_t [N_LVL-1:0]            flags_d;
  logic [N_LVL-1:0][BYTE_W-1:0]      main_b, aux_b;

  assign temp_lim[LVL_ALM] = {temp_hi_alm_i, temp_lo_alm_i};
  assign temp_lim[LVL_WRN] = {temp_hi_wrn_i, temp_lo_wrn_i};
  assign vcc_lim[LVL_ALM]  = {vcc_hi_alm_i, vcc_lo_alm_i};
  assign vcc_lim[LVL_WRN]  = {vcc_hi_wrn_i, vcc_lo_wrn_i};
  assign mgn_lim[LVL_ALM]  = mgn_lo_alm_i;
  assign mgn_lim[LVL_WRN]  = mgn_lo_wrn_i;

  dlm_chan #(.W(TEMP_W), .SIGNED_CMP(1'b1), .HAS_HIGH(1'b1)) i_temp (
    .val_i(temp_i), .lim_i(temp_lim), .flag_o(temp_hit)
  );

  dlm_chan #(.W(VCC_W), .SIGNED_CMP(1'b0), .HAS_HIGH(1'b1)) i_vcc (
    .val_i(vcc_i), .lim_i(vcc_lim), .flag_o(vcc_hit)
  );

  dlm_chan #(.W(MGN_W), .SIGNED_CMP(1'b1), .HAS_HIGH(1'b0)) i_mgn (
    .val_i(margin_i), .lim_i(mgn_lim), .flag_o(mgn_hit)
  );

  generate
    for (genvar l = 0; l < N_LVL; l++) begin : g_flags
      assign flags_d[l] = '{t_hi: temp_hit[l][1], t_lo: temp_hit[l][0],
                            v_hi: vcc_hit[l][1],  v_lo: vcc_hit[l][0],
                            m_lo: mgn_hit[l][0]};
    end
  endgenerate

  dlm_flag_reg i_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sample_vld_i(sample_vld_i),
    .flags_d_i   (flags_d),
    .main_o      (main_b),
    .aux_o       (aux_b)
  );

  assign alarm_main_o = main_b[LVL_ALM];
  assign alarm_aux_o  = aux_b[LVL_ALM];
  assign warn_main_o  = main_b[LVL_WRN];
  assign warn_aux_o   = aux_b[LVL_WRN];

  assert_temp_hi_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_vld_i && ($signed(temp_i) > $signed(temp_hi_alm_i)) |=> alarm_main_o[POS_T_HI]);

  assert_vcc_lo_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_vld_i && (vcc_i < vcc_lo_alm_i) |=> alarm_main_o[POS_V_LO]);

  assert_mgn_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_vld_i && ($signed(margin_i) >= $signed(mgn_lo_wrn_i)) |=> !warn_aux_o[POS_M_LO]);
endmodule

// File: tb/test_diag_limit_monitor.sv
module test_diag_limit_monitor;
  import dlm_pkg::*;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WDOG_CYC   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic [15:0] temp = '0, vcc = '0;
  logic [7:0]  mgn = '0;
  logic [15:0] t_ha, t_la, t_hw, t_lw, v_ha, v_la, v_hw, v_lw;
  logic [7:0]  m_la, m_lw;
  logic [7:0]  am, aa, wm, wa;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  diag_limit_monitor i_diag_limit_monitor (
    .clk_i(clk), .rst_ni(rst_n), .sample_vld_i(vld),
    .temp_i(temp), .vcc_i(vcc), .margin_i(mgn),
    .temp_hi_alm_i(t_ha), .temp_lo_alm_i(t_la),
    .temp_hi_wrn_i(t_hw), .temp_lo_wrn_i(t_lw),
    .vcc_hi_alm_i(v_ha), .vcc_lo_alm_i(v_la),
    .vcc_hi_wrn_i(v_hw), .vcc_lo_wrn_i(v_lw),
    .mgn_lo_alm_i(m_la), .mgn_lo_wrn_i(m_lw),
    .alarm_main_o(am), .alarm_aux_o(aa), .warn_main_o(wm), .warn_aux_o(wa)
  );

  function automatic logic [7:0] main_byte(logic [15:0] th, logic [15:0] tl,
                                           logic [15:0] vh, logic [15:0] vl);
    main_byte = {($signed(temp) > $signed(th)), ($signed(temp) < $signed(tl)),
                 (vcc > vh), (vcc < vl), 4'b0000};
  endfunction

  function automatic logic [31:0] model();
    logic [7:0] a_m, a_x, w_m, w_x;
    a_m = main_byte(t_ha, t_la, v_ha, v_la);
    w_m = main_byte(t_hw, t_lw, v_hw, v_lw);
    a_x = {2'b00, ($signed(mgn) < $signed(m_la)), 5'b00000};
    w_x = {2'b00, ($signed(mgn) < $signed(m_lw)), 5'b00000};
    model = {a_m, a_x, w_m, w_x};
  endfunction

  task automatic check(string tag, logic [31:0] exp);
    checks++;
    if ({am, aa, wm, wa} !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, {am, aa, wm, wa}, exp);
    end
  endtask

  task automatic set_defaults();
    t_ha = DEF_TEMP_HI_ALM; t_la = DEF_TEMP_LO_ALM;
    t_hw = DEF_TEMP_HI_WRN; t_lw = DEF_TEMP_LO_WRN;
    v_ha = DEF_VCC_HI_ALM;  v_la = DEF_VCC_LO_ALM;
    v_hw = DEF_VCC_HI_WRN;  v_lw = DEF_VCC_LO_WRN;
    m_la = DEF_MGN_LO_ALM;  m_lw = DEF_MGN_LO_WRN;
  endtask

  // one strobe, result sampled at the next falling edge
  task automatic sample(logic [15:0] t, logic [15:0] v, logic [7:0] m,
                        string tag, logic [31:0] exp);
    @(negedge clk);
    temp = t; vcc = v; mgn = m; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    check(tag, exp);
  endtask

  task automatic sample_model(logic [15:0] t, logic [15:0] v, logic [7:0] m, string tag);
    logic [31:0] e;
    @(negedge clk);
    temp = t; vcc = v; mgn = m; vld = 1'b1;
    e = model();
    @(negedge clk);
    vld = 1'b0;
    check(tag, e);
  endtask

  task automatic test_reset();
    @(negedge clk);
    check("R1 in reset", 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 no strobe after reset", 32'h0);
  endtask

  task automatic test_nominal();
    sample(16'h1900, 16'h80E8, 8'h40, "R10 nominal in range", 32'h0);
  endtask

  task automatic test_temp();
    sample(16'h7300, 16'h80E8, 8'h40, "R2 temp equals high alarm", 32'h0000_8000);
    sample(16'h7301, 16'h80E8, 8'h40, "R2 temp above high alarm", 32'h8000_8000);
    sample(16'h7FFF, 16'h80E8, 8'h40, "R2 temp max positive", 32'h8000_8000);
    sample(16'hD800, 16'h80E8, 8'h40, "R3 temp equals low alarm", 32'h0000_4000);
    sample(16'hD7FF, 16'h80E8, 8'h40, "R3 temp below low alarm", 32'h4000_4000);
    sample(16'h8000, 16'h80E8, 8'h40, "R3 temp most negative", 32'h4000_4000);
    sample(16'hE800, 16'h80E8, 8'h40, "R3 negative temp inside range", 32'h0);
  endtask

  task automatic test_vcc();
    sample(16'h1900, 16'h9858, 8'h40, "R4 vcc equals high alarm", 32'h0000_2000);
    sample(16'h1900, 16'h9859, 8'h40, "R4 vcc above high alarm", 32'h2000_2000);
    sample(16'h1900, 16'hFFFF, 8'h40, "R4 vcc max is unsigned high", 32'h2000_2000);
    sample(16'h1900, 16'h6978, 8'h40, "R5 vcc equals low alarm", 32'h0000_1000);
    sample(16'h1900, 16'h6977, 8'h40, "R5 vcc below low alarm", 32'h1000_1000);
    sample(16'h1900, 16'h0000, 8'h40, "R5 vcc zero", 32'h1000_1000);
  endtask

  task automatic test_margin();
    sample(16'h1900, 16'h80E8, 8'h12, "R6 margin equals warning", 32'h0);
    sample(16'h1900, 16'h80E8, 8'h11, "R6 margin below warning", 32'h0000_0020);
    sample(16'h1900, 16'h80E8, 8'h08, "R6 margin equals alarm", 32'h0000_0020);
    sample(16'h1900, 16'h80E8, 8'h07, "R6 margin below alarm", 32'h0020_0020);
    sample(16'h1900, 16'h80E8, 8'hF0, "R6 margin negative", 32'h0020_0020);
    sample(16'h1900, 16'h80E8, 8'h7F, "R6 margin max positive", 32'h0);
  endtask

  task automatic test_all_and_reserved();
    sample(16'h8000, 16'hFFFF, 8'h80, "R8 reserved stay zero with all flags", 32'h6020_6020);
    sample(16'h7FFF, 16'h0000, 8'h80, "R8 reserved stay zero mixed", 32'h9020_9020);
  endtask

  task automatic test_independent_levels();
    t_hw = 16'h1000; t_ha = 16'h7000;
    v_lw = 16'h9000; v_la = 16'h1000;
    m_lw = 8'hC0;    m_la = 8'h50;
    sample_model(16'h2000, 16'h5000, 8'h20, "R7 alarm and warning limits separate");
    sample_model(16'h7100, 16'h0800, 8'hB0, "R7 both levels hit");
    set_defaults();
  endtask

  task automatic test_hold();
    sample(16'h7400, 16'h80E8, 8'h40, "R9 flag set by strobe", 32'h8000_8000);
    @(negedge clk);
    temp = 16'h0000; vcc = 16'hFFFF; mgn = 8'h80;
    t_ha = 16'h8000;
    repeat (4) @(negedge clk);
    check("R9 holds without strobe", 32'h8000_8000);
    set_defaults();
    @(negedge clk);
    temp = 16'h1900; vcc = 16'h80E8; mgn = 8'h40; vld = 1'b1;
    #1;
    check("R9 not visible before edge", 32'h8000_8000);
    @(negedge clk);
    vld = 1'b0;
    check("R10 in-range strobe clears", 32'h0);
  endtask

  task automatic test_reset_midrun();
    sample(16'h8000, 16'hFFFF, 8'h80, "R1 flags set before reset", 32'h6020_6020);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset clears", 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 stays clear after reset", 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    set_defaults();
    test_reset();
    test_nominal();
    test_temp();
    test_vcc();
    test_margin();
    test_all_and_reserved();
    test_independent_levels();
    test_hold();
    test_reset_midrun();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule